// File: doc/BRIEF.md
# Equalizer Control Source Selector

This block sits between the board-level configuration inputs of a four-lane linear equalizer and the analog lanes. For every lane it produces a 4-bit peaking code, a 2-bit flat-gain code, a 2-bit output-amplitude code and a power-down bit. The codes come from one of two places. In pin mode they come from three three-level control pins, scaled by a channel-length select. In register mode they can instead come from per-lane configuration bytes held by a serial register slave.

A mode strap chooses between pin mode and register mode. The strap is captured only while the synchronous reset is asserted. A three-level enable input does three jobs: it powers the lanes down, it powers them up, or it holds the register file in reset. When it asks for register reset, the block raises a request toward the register slave. In pin mode the enable level acts at all times. In register mode it only takes effect at the moment the block leaves a reset. Every output is registered on the system clock.

Top module: `eq_ctrl_select`

## Requirements
- R1: Three-level inputs are coded 00 = low, 01 = open, 10 = high, and the code 11 is treated as open. The reach input selects a short channel only when it is high; low and open both select a long channel.
- R2: In pin mode the peaking code is set as follows. For a long channel: high gives 1110, open gives 1001, low gives 0101. For a short channel: high gives 1001, open gives 0101, low gives 0011.
- R3: In pin mode the flat-gain code is set as follows. For a long channel: high gives 11, open gives 10, low gives 01. For a short channel: high gives 10, open gives 01, low gives 00.
- R4: In pin mode the amplitude code ignores the reach input: high gives 11, open gives 10, low gives 01.
- R5: In pin mode every lane carries the same codes. The control register and the lane configuration bytes have no effect on any code or power-down output.
- R6: A strap value of 1 selects register mode and 0 selects pin mode. The strap is sampled only while rst is high, and later changes have no effect.
- R7: In register mode with control bit NUM_LANES (bit 4) set, lane i takes its codes from lane_cfg[8i+7:8i]: peaking in bits 7:4, flat gain in bits 3:2, amplitude in bits 1:0. With that bit clear, all lanes use the pin-derived codes.
- R8: In register mode, control bit NUM_LANES-1-i disables lane i (bit 3 is lane 0, bit 0 is lane 3). A disabled lane has its power-down output forced to 1, OR'd with the global power-down.
- R9: While enable is low, the register-reset request is 1 and all lanes are powered down, in both modes. Otherwise the request is 0.
- R10: In pin mode, enable high powers all lanes down and enable open powers them on. The level is followed continuously.
- R11: In register mode, the enable level (high = down, open = on) is taken at the first non-low cycle after rst or after an enable-low interval. Later high/open changes have no effect.
- R12: All outputs appear one clock after their inputs. During reset the codes are 0, all power-down bits are 1, and the request is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_reg_mode | input | 1 | Mode strap, 1 = register mode |
| lvl_peak | input | 2 | Peaking pin level |
| lvl_gain | input | 2 | Flat-gain pin level |
| lvl_amp | input | 2 | Output-level pin level |
| lvl_reach | input | 2 | Channel-length select level |
| lvl_enable | input | 2 | Enable/reset pin level |
| ctrl_reg | input | NUM_LANES+1 | Source select (top bit) and lane disables |
| lane_cfg | input | NUM_LANES*8 | Per-lane configuration bytes |
| peak_code | output | NUM_LANES*4 | Peaking code, lane i at [4i+3:4i] |
| gain_code | output | NUM_LANES*2 | Flat-gain code, lane i at [2i+1:2i] |
| amp_code | output | NUM_LANES*2 | Amplitude code, lane i at [2i+1:2i] |
| lane_pdn | output | NUM_LANES | Per-lane power-down |
| regs_reset_req | output | 1 | Register-reset request |

## Verification
The hardest behaviour to reach from the ports is the one-shot capture of the enable level in register mode. The captured value can only be seen by changing the enable level afterwards and showing that the power-down outputs stay put. The bench therefore leaves reset with enable high and moves enable to open while holding the control register still. It then pulses enable low and returns it to open. After that it moves enable back to high and shows the newly captured level survives. Strap immunity is shown in the same sequence: the strap is flipped right after reset, and the outputs that pin mode would change stay unchanged.

// File: rtl/eq_ctrl_pkg.sv
package eq_ctrl_pkg;

    localparam int PEAK_W = 4;
    localparam int GAIN_W = 2;
    localparam int AMP_W  = 2;
    localparam int CFG_W  = PEAK_W + GAIN_W + AMP_W;

    typedef enum logic [1:0] {
        LVL_LOW  = 2'b00,
        LVL_OPEN = 2'b01,
        LVL_HIGH = 2'b10,
        LVL_RSVD = 2'b11
    } lvl_e;

    typedef struct packed {
        logic [PEAK_W-1:0] peak;
        logic [GAIN_W-1:0] gain;
        logic [AMP_W-1:0]  amp;
    } lane_cfg_t;

    // Unused code 11 folds onto the open level.
    function automatic lvl_e lvl_clean(input logic [1:0] raw);
        lvl_e l;
        l = lvl_e'(raw);
        if (l == LVL_RSVD) l = LVL_OPEN;
        return l;
    endfunction

    function automatic logic [PEAK_W-1:0] peak_from_pin(input lvl_e l, input logic short_ch);
        logic [PEAK_W-1:0] c;
        case (l)
            LVL_HIGH: c = short_ch ? 4'b1001 : 4'b1110;
            LVL_LOW:  c = short_ch ? 4'b0011 : 4'b0101;
            default:  c = short_ch ? 4'b0101 : 4'b1001;
        endcase
        return c;
    endfunction

    function automatic logic [GAIN_W-1:0] gain_from_pin(input lvl_e l, input logic short_ch);
        logic [GAIN_W-1:0] c;
        case (l)
            LVL_HIGH: c = short_ch ? 2'b10 : 2'b11;
            LVL_LOW:  c = short_ch ? 2'b00 : 2'b01;
            default:  c = short_ch ? 2'b01 : 2'b10;
        endcase
        return c;
    endfunction

    function automatic logic [AMP_W-1:0] amp_from_pin(input lvl_e l);
        logic [AMP_W-1:0] c;
        case (l)
            LVL_HIGH: c = 2'b11;
            LVL_LOW:  c = 2'b01;
            default:  c = 2'b10;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/eq_pin_decode.sv
module eq_pin_decode
    import eq_ctrl_pkg::*;
(
    input  logic [1:0] lvl_peak,
    input  logic [1:0] lvl_gain,
    input  logic [1:0] lvl_amp,
    input  logic [1:0] lvl_reach,
    output lane_cfg_t  pin_cfg
);
    logic short_ch;

    // Only a firm high selects the short-channel table.
    assign short_ch = (lvl_clean(lvl_reach) == LVL_HIGH);

    always_comb begin
        pin_cfg.peak = peak_from_pin(lvl_clean(lvl_peak), short_ch);
        pin_cfg.gain = gain_from_pin(lvl_clean(lvl_gain), short_ch);
        pin_cfg.amp  = amp_from_pin(lvl_clean(lvl_amp));
    end
endmodule

// File: rtl/eq_power_ctl.sv
module eq_power_ctl
    import eq_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       strap_reg_mode,
    input  logic [1:0] lvl_enable,
    output logic       reg_mode,
    output logic       glob_pdn,
    output logic       hold_regs
);
    lvl_e en_lvl;
    logic strap_q;
    logic arm_q;
    logic hold_q;

    assign en_lvl = lvl_clean(lvl_enable);

    // Strap is frozen at reset; enable level is sampled once after any reset.
    always_ff @(posedge clk) begin
        if (rst) begin
            strap_q <= strap_reg_mode;
            arm_q   <= 1'b1;
            hold_q  <= 1'b0;
        end else if (en_lvl == LVL_LOW) begin
            arm_q   <= 1'b1;
        end else if (arm_q) begin
            hold_q  <= (en_lvl == LVL_HIGH);
            arm_q   <= 1'b0;
        end
    end

    assign reg_mode  = strap_q;
    assign hold_regs = (en_lvl == LVL_LOW);

    always_comb begin
        if (en_lvl == LVL_LOW)
            glob_pdn = 1'b1;
        else if (!strap_q)
            glob_pdn = (en_lvl == LVL_HIGH);
        else if (arm_q)
            glob_pdn = (en_lvl == LVL_HIGH);
        else
            glob_pdn = hold_q;
    end
endmodule

// File: rtl/eq_lane_slice.sv
module eq_lane_slice
    import eq_ctrl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  lane_cfg_t pin_cfg,
    input  lane_cfg_t reg_cfg,
    input  logic      use_reg,
    input  logic      lane_off,
    input  logic      glob_pdn,
    output lane_cfg_t cfg_q,
    output logic      pdn_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            pdn_q <= 1'b1;
        end else begin
            cfg_q <= use_reg ? reg_cfg : pin_cfg;
            pdn_q <= glob_pdn | lane_off;
        end
    end
endmodule

// File: rtl/eq_ctrl_select.sv
module eq_ctrl_select
    import eq_ctrl_pkg::*;
#(
    parameter int NUM_LANES = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        strap_reg_mode,
    input  logic [1:0]                  lvl_peak,
    input  logic [1:0]                  lvl_gain,
    input  logic [1:0]                  lvl_amp,
    input  logic [1:0]                  lvl_reach,
    input  logic [1:0]                  lvl_enable,
    input  logic [NUM_LANES:0]          ctrl_reg,
    input  logic [NUM_LANES*CFG_W-1:0]  lane_cfg,
    output logic [NUM_LANES*PEAK_W-1:0] peak_code,
    output logic [NUM_LANES*GAIN_W-1:0] gain_code,
    output logic [NUM_LANES*AMP_W-1:0]  amp_code,
    output logic [NUM_LANES-1:0]        lane_pdn,
    output logic                        regs_reset_req
);
    localparam int SEL_BIT = NUM_LANES;

    lane_cfg_t pin_cfg;
    logic      reg_mode;
    logic      glob_pdn;
    logic      hold_regs;
    logic      use_reg;

    eq_pin_decode u_pins (
        .lvl_peak  (lvl_peak),
        .lvl_gain  (lvl_gain),
        .lvl_amp   (lvl_amp),
        .lvl_reach (lvl_reach),
        .pin_cfg   (pin_cfg)
    );

    eq_power_ctl u_pwr (
        .clk            (clk),
        .rst            (rst),
        .strap_reg_mode (strap_reg_mode),
        .lvl_enable     (lvl_enable),
        .reg_mode       (reg_mode),
        .glob_pdn       (glob_pdn),
        .hold_regs      (hold_regs)
    );

    assign use_reg = reg_mode & ctrl_reg[SEL_BIT];

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        lane_cfg_t cfg_q;
        eq_lane_slice u_slice (
            .clk      (clk),
            .rst      (rst),
            .pin_cfg  (pin_cfg),
            .reg_cfg  (lane_cfg_t'(lane_cfg[i*CFG_W +: CFG_W])),
            .use_reg  (use_reg),
            .lane_off (reg_mode & ctrl_reg[NUM_LANES-1-i]),
            .glob_pdn (glob_pdn),
            .cfg_q    (cfg_q),
            .pdn_q    (lane_pdn[i])
        );
        assign peak_code[i*PEAK_W +: PEAK_W] = cfg_q.peak;
        assign gain_code[i*GAIN_W +: GAIN_W] = cfg_q.gain;
        assign amp_code[i*AMP_W +: AMP_W]    = cfg_q.amp;
    end

    always_ff @(posedge clk) begin
        if (rst) regs_reset_req <= 1'b1;
        else     regs_reset_req <= hold_regs;
    end
endmodule

// File: rtl/eq_ctrl_checker.sv
module eq_ctrl_checker #(
    parameter int NUM_LANES = 4
) (
    input logic                   clk,
    input logic                   rst,
    input logic [1:0]             lvl_enable,
    input logic [NUM_LANES:0]     ctrl_reg,
    input logic                   reg_mode,
    input logic [NUM_LANES*4-1:0] peak_code,
    input logic [NUM_LANES-1:0]   lane_pdn,
    input logic                   regs_reset_req
);
    AST_REQ_ON_EN_LOW: assert property (@(posedge clk) disable iff (rst)
        (lvl_enable == 2'b00) |=> regs_reset_req);                       // R9
    AST_NO_REQ_EN_UP: assert property (@(posedge clk) disable iff (rst)
        (lvl_enable != 2'b00) |=> !regs_reset_req);                      // R9
    AST_ALL_DOWN_EN_LOW: assert property (@(posedge clk) disable iff (rst)
        (lvl_enable == 2'b00) |=> (&lane_pdn));                          // R9
    AST_PIN_OPEN_ON: assert property (@(posedge clk) disable iff (rst)
        (!reg_mode && lvl_enable == 2'b01) |=> (lane_pdn == '0));        // R10
    AST_PIN_HIGH_DOWN: assert property (@(posedge clk) disable iff (rst)
        (!reg_mode && lvl_enable == 2'b10) |=> (&lane_pdn));             // R10
    AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(reg_mode));                                     // R6
    AST_REG_EN_STICKY: assert property (@(posedge clk) disable iff (rst)
        (reg_mode && !$past(rst) && lvl_enable != 2'b00 &&
         $past(lvl_enable) != 2'b00 && $stable(ctrl_reg))
        |=> $stable(lane_pdn));                                          // R11

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_pk
        AST_PIN_PEAK_LEGAL: assert property (@(posedge clk) disable iff (rst)
            !reg_mode |=> (peak_code[i*4 +: 4] == 4'b1110 ||
                           peak_code[i*4 +: 4] == 4'b1001 ||
                           peak_code[i*4 +: 4] == 4'b0101 ||
                           peak_code[i*4 +: 4] == 4'b0011));            // R2
    end
endmodule

bind eq_ctrl_select eq_ctrl_checker #(.NUM_LANES(NUM_LANES)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .lvl_enable     (lvl_enable),
    .ctrl_reg       (ctrl_reg),
    .reg_mode       (reg_mode),
    .peak_code      (peak_code),
    .lane_pdn       (lane_pdn),
    .regs_reset_req (regs_reset_req)
);

// File: tb/tb_eq_ctrl_select.sv
`timescale 1ns/1ps
module tb_eq_ctrl_select;
    localparam int NL = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        strap = 1'b0;
    logic [1:0]  lp = 2'b01, lg = 2'b01, la = 2'b01, lr = 2'b01, le = 2'b01;
    logic [NL:0] ctrl = '0;
    logic [NL*8-1:0] lcfg = '0;
    logic [NL*4-1:0] peak;
    logic [NL*2-1:0] gain;
    logic [NL*2-1:0] amp;
    logic [NL-1:0]   pdn;
    logic            rreq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    eq_ctrl_select #(.NUM_LANES(NL)) dut (
        .clk(clk), .rst(rst), .strap_reg_mode(strap),
        .lvl_peak(lp), .lvl_gain(lg), .lvl_amp(la), .lvl_reach(lr), .lvl_enable(le),
        .ctrl_reg(ctrl), .lane_cfg(lcfg),
        .peak_code(peak), .gain_code(gain), .amp_code(amp),
        .lane_pdn(pdn), .regs_reset_req(rreq)
    );

    function automatic int nrm(input int l);
        return (l == 3) ? 1 : l;
    endfunction

    function automatic int e_peak(input int l, input int r);
        int s = (nrm(r) == 2);
        case (nrm(l))
            2: return s ? 9 : 14;
            1: return s ? 5 : 9;
            default: return s ? 3 : 5;
        endcase
    endfunction

    function automatic int e_gain(input int l, input int r);
        int s = (nrm(r) == 2);
        return nrm(l) + 1 - s;
    endfunction

    function automatic int e_amp(input int l);
        return nrm(l) + 1;
    endfunction

    function automatic logic [31:0] rep(input int v, input int w);
        logic [31:0] x = '0;
        for (int i = 0; i < NL; i++) x = x | (32'(v) << (i * w));
        return x;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk_pin_codes(input string tag);
        check({tag, " peak"}, 32'(peak), rep(e_peak(lp, lr), 4));
        check({tag, " gain"}, 32'(gain), rep(e_gain(lg, lr), 2));
        check({tag, " amp"},  32'(amp),  rep(e_amp(la), 2));
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] ep, eg, ea, ed;
        // R12 reset values
        step(3);
        check("R12 reset peak", 32'(peak), 0);
        check("R12 reset pdn", 32'(pdn), 32'hF);
        check("R12 reset req", 32'(rreq), 1);

        // Pin mode; control register and lane bytes set but must be ignored (R5)
        ctrl = 5'h1F;
        lcfg = 32'hA5C3_7E18;
        rst = 1'b0;
        step(2);
        check("R10 open powers on / R5 disables ignored", 32'(pdn), 0);
        check("R9 request low", 32'(rreq), 0);

        // R1..R5 sweep over all encodings
        for (int r = 0; r < 4; r++)
            for (int p = 0; p < 4; p++)
                for (int g = 0; g < 4; g++)
                    for (int a = 0; a < 4; a++) begin
                        lp = 2'(p); lg = 2'(g); la = 2'(a); lr = 2'(r);
                        step(1);
                        chk_pin_codes("R1 R2 R3 R4 R5 pin sweep");
                    end

        // R10 continuous enable in pin mode
        le = 2'b10; step(1);
        check("R10 high powers down", 32'(pdn), 32'hF);
        le = 2'b01; step(1);
        check("R10 open powers up again", 32'(pdn), 0);
        le = 2'b11; step(1);
        check("R1 code 11 acts as open", 32'(pdn), 0);
        le = 2'b00; step(1);
        check("R9 low requests reset", 32'(rreq), 1);
        check("R9 low powers down", 32'(pdn), 32'hF);
        le = 2'b01; step(1);
        check("R9 request drops", 32'(rreq), 0);

        // Register mode entry with enable high captured
        rst = 1'b1; strap = 1'b1; le = 2'b10; ctrl = 5'h00;
        step(2);
        rst = 1'b0;
        step(1);
        strap = 1'b0;              // R6: must have no effect now
        step(2);
        check("R11 captured high", 32'(pdn), 32'hF);
        le = 2'b01; step(3);
        check("R11 R6 open ignored after capture", 32'(pdn), 32'hF);

        // Enable low pulse, then reopen: capture open
        le = 2'b00; step(1);
        check("R9 request in register mode", 32'(rreq), 1);
        le = 2'b01; step(2);
        check("R11 recapture open", 32'(pdn), 0);
        le = 2'b10; step(3);
        check("R11 high ignored after capture", 32'(pdn), 0);

        // R7 register source
        for (int k = 0; k < 16; k++) begin
            for (int i = 0; i < NL; i++) lcfg[i*8 +: 8] = 8'((k * 37 + i * 73 + 11) & 8'hFF);
            ctrl = 5'h10;
            step(1);
            ep = '0; eg = '0; ea = '0;
            for (int i = 0; i < NL; i++) begin
                ep[i*4 +: 4] = lcfg[i*8 + 4 +: 4];
                eg[i*2 +: 2] = lcfg[i*8 + 2 +: 2];
                ea[i*2 +: 2] = lcfg[i*8 +: 2];
            end
            check("R7 reg peak", 32'(peak), ep);
            check("R7 reg gain", 32'(gain), eg);
            check("R7 reg amp", 32'(amp), ea);
            check("R6 strap flip ignored", 32'(pdn), 0);
        end
        ctrl = 5'h00; lp = 2'b10; lg = 2'b00; la = 2'b10; lr = 2'b10;
        step(1);
        chk_pin_codes("R7 select clear uses pins");

        // R8 lane disables
        for (int d = 0; d < 16; d++) begin
            ctrl = {1'b1, 4'(d)};
            step(1);
            ed = '0;
            for (int i = 0; i < NL; i++) ed[i] = d[NL-1-i];
            check("R8 lane disable map", 32'(pdn), ed);
        end
        le = 2'b00; ctrl = 5'h10; step(1);
        check("R9 low overrides in register mode", 32'(pdn), 32'hF);
        le = 2'b01; step(2);
        check("R8 R11 back on", 32'(pdn), 0);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule